// File: doc/BRIEF.md
# Auto-Increment Color Lookup Table

This block holds a 256-entry table of 24-bit colors behind a small byte-wide register interface. Software chooses a starting entry through an index register and then streams color bytes through a data register. Each color is given as three separate bytes: red first, then green, then blue. A hidden component counter tracks which byte comes next. The entry is written to storage only when its blue byte arrives. The index then moves to the next entry by itself, so a whole table loads with one index write followed by 768 data writes.

A separate lookup port turns an 8-bit pixel value into a 24-bit color. Before the lookup, the pixel value is ANDed with a programmable mask. A control bit chooses how color bytes are interpreted:

- **Full 8-bit mode:** components are stored and returned unchanged.
- **Narrow 6-bit mode:** the top two bits of each written byte are dropped, and each stored component is shifted left by two on the way out.

Top module: `pal_write_port`

## Requirements
- R1: While reset is held, `pix_rgb` is 0. After reset the index reads 0, the mask reads 0xFF, the control register reads 0 (6-bit mode), and the next data byte is taken as red.
- R2: Writing address 0 (index) loads the index from `reg_wdata` and returns the component counter to red, which discards any partly written triple.
- R3: Data writes (address 1) are taken in the order red, green, blue. The entry at the current index changes only when blue is written, and it receives all three components together.
- R4: After each blue write the index rises by one. It wraps from 255 to 0.
- R5: Reading address 0 returns the current index on `reg_rdata` in the same cycle and returns the component counter to red.
- R6: The lookup uses `pix_idx AND mask`, where the mask is written at address 2 and read back at address 2.
- R7: Bit 0 of the control register (address 3) set to 1 selects 8-bit mode: the lookup returns stored bytes unchanged. With the bit at 0, bits 7:6 of each written data byte are discarded, and each stored component is returned as `{c[5:0],2'b00}`.
- R8: `pix_rgb = {red, green, blue}` (red in bits 23:16) for the `pix_idx` sampled at the previous rising clock edge. The latency is one cycle.
- R9: A read of address 1 returns 0. When `reg_rd_en` is low, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 index, 1 data, 2 mask, 3 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational during `reg_rd_en` |
| pix_idx | input | 8 | Pixel value to translate |
| pix_rgb | output | 24 | Color for the previous cycle's pixel value |

## Verification
Register reads are combinational, so the bench drives the read at a falling edge and samples `reg_rdata` one time step later, before the next rising edge. The counter clearing caused by that read takes effect at that rising edge. A committed entry becomes visible to a lookup whose pixel value is presented after the committing edge. Every lookup check therefore presents `pix_idx` at a falling edge and compares `pix_rgb` at the following falling edge, which is exactly one register stage later. The expected color for each entry comes from a shadow table in the bench, built from the written bytes and the mode in force, including the 6-bit truncation and the shift on output.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    RA_INDEX = 2'd0,
    RA_DATA  = 2'd1,
    RA_MASK  = 2'd2,
    RA_CTRL  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int NARROW_DROP = 2;

endpackage

// File: rtl/pal_regs.sv
module pal_regs #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            addr,
  input  logic [COMP_W-1:0]     wdata,
  output logic [COMP_W-1:0]     rdata,
  output logic [IDX_W-1:0]      mask,
  output logic                  mode8,
  output logic                  commit,
  output logic [IDX_W-1:0]      commit_idx,
  output logic [3*COMP_W-1:0]   commit_rgb
);
  import pal_pkg::*;

  localparam int NARROW_W = COMP_W - NARROW_DROP;

  logic [IDX_W-1:0]  idx_q, idx_d;
  phase_e            phase_q, phase_d;
  logic [COMP_W-1:0] red_q, red_d, grn_q, grn_d;
  logic [IDX_W-1:0]  mask_q, mask_d;
  logic              mode8_q, mode8_d;
  logic              reg_en;
  logic [COMP_W-1:0] comp_in;
  reg_addr_e         ra;

  assign ra      = reg_addr_e'(addr);
  assign reg_en  = wr_en | rd_en;
  assign comp_in = mode8_q ? wdata : {{NARROW_DROP{1'b0}}, wdata[NARROW_W-1:0]};

  always_comb begin
    idx_d   = idx_q;
    phase_d = phase_q;
    red_d   = red_q;
    grn_d   = grn_q;
    mask_d  = mask_q;
    mode8_d = mode8_q;
    if (wr_en) begin
      case (ra)
        RA_INDEX: begin
          idx_d   = wdata[IDX_W-1:0];
          phase_d = PH_RED;
        end
        RA_DATA: begin
          case (phase_q)
            PH_RED: begin
              red_d   = comp_in;
              phase_d = PH_GRN;
            end
            PH_GRN: begin
              grn_d   = comp_in;
              phase_d = PH_BLU;
            end
            PH_BLU: begin
              phase_d = PH_RED;
              idx_d   = idx_q + 1'b1;
            end
            default: phase_d = PH_RED;
          endcase
        end
        RA_MASK: mask_d  = wdata[IDX_W-1:0];
        RA_CTRL: mode8_d = wdata[0];
        default: ;
      endcase
    end else if (rd_en && ra == RA_INDEX) begin
      phase_d = PH_RED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
      red_q   <= '0;
      grn_q   <= '0;
      mask_q  <= '1;
      mode8_q <= 1'b0;
    end else if (reg_en) begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
      red_q   <= red_d;
      grn_q   <= grn_d;
      mask_q  <= mask_d;
      mode8_q <= mode8_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (ra)
        RA_INDEX: rdata = COMP_W'(idx_q);
        RA_MASK:  rdata = COMP_W'(mask_q);
        RA_CTRL:  rdata = COMP_W'(mode8_q);
        default:  rdata = '0;
      endcase
    end
  end

  assign commit     = wr_en && (ra == RA_DATA) && (phase_q == PH_BLU);
  assign commit_idx = idx_q;
  assign commit_rgb = {red_q, grn_q, comp_in};
  assign mask       = mask_q;
  assign mode8      = mode8_q;

  // R4
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> idx_q == $past(idx_q) + 1'b1);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ra == RA_INDEX) |=> (idx_q == $past(wdata[IDX_W-1:0]) && phase_q == PH_RED));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && ra == RA_INDEX) |=> phase_q == PH_RED);

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (ra == RA_INDEX || ra == RA_DATA)) |=> $stable(idx_q));

endmodule

// File: rtl/pal_mem.sv
module pal_mem #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    pix_idx,
  input  logic [IDX_W-1:0]    mask,
  input  logic                mode8,
  output logic [IDX_W-1:0]    mem_raddr,
  input  logic [3*COMP_W-1:0] mem_rdata,
  output logic [3*COMP_W-1:0] pix_rgb
);
  import pal_pkg::*;

  localparam int NARROW_W = COMP_W - NARROW_DROP;

  logic [3*COMP_W-1:0] color_d, color_q;

  assign mem_raddr = pix_idx & mask;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [COMP_W-1:0] raw;
    assign raw = mem_rdata[c*COMP_W +: COMP_W];
    assign color_d[c*COMP_W +: COMP_W] =
      mode8 ? raw : {raw[NARROW_W-1:0], {NARROW_DROP{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) color_q <= '0;
    else        color_q <= color_d;
  end

  assign pix_rgb = color_q;

  // R7
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode8 |=> (pix_rgb[1:0] == 2'b00 && pix_rgb[COMP_W+1:COMP_W] == 2'b00
                && pix_rgb[2*COMP_W+1:2*COMP_W] == 2'b00));

endmodule

// File: rtl/pal_write_port.sv
module pal_write_port #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [1:0]          reg_addr,
  input  logic [COMP_W-1:0]   reg_wdata,
  output logic [COMP_W-1:0]   reg_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int RGB_W = 3 * COMP_W;

  logic [IDX_W-1:0] mask;
  logic             mode8;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  logic [RGB_W-1:0] commit_rgb;
  logic [IDX_W-1:0] mem_raddr;
  logic [RGB_W-1:0] mem_rdata;

  pal_regs #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .mask       (mask),
    .mode8      (mode8),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_rgb (commit_rgb)
  );

  pal_mem #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_mem (
    .clk   (clk),
    .we    (commit),
    .waddr (commit_idx),
    .wdata (commit_rgb),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  pal_lookup #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_idx   (pix_idx),
    .mask      (mask),
    .mode8     (mode8),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .pix_rgb   (pix_rgb)
  );

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |-> reg_rdata == '0);

endmodule

// File: tb/tb_pal_write_port.sv
module tb_pal_write_port;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_rd_en;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  int n_chk;
  int n_fail;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;
  logic [7:0] m_sr, m_sg;
  logic [7:0] m_mask;
  logic       m_mode8;

  pal_write_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 2'd0) begin m_idx = d; m_ph = 0; end
    else if (a == 2'd2) m_mask = d;
    else if (a == 2'd3) m_mode8 = d[0];
    else begin
      logic [7:0] v;
      v = m_mode8 ? d : {2'b00, d[5:0]};
      if (m_ph == 0) begin m_sr = v; m_ph = 1; end
      else if (m_ph == 1) begin m_sg = v; m_ph = 2; end
      else begin
        m_r[m_idx] = m_sr; m_g[m_idx] = m_sg; m_b[m_idx] = v;
        m_idx = m_idx + 8'd1; m_ph = 0;
      end
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
    if (a == 2'd0) m_ph = 0;
  endtask

  function automatic logic [7:0] outc(input logic [7:0] v);
    return m_mode8 ? v : {v[5:0], 2'b00};
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [7:0] p);
    logic [7:0] e;
    e = p & m_mask;
    return {outc(m_r[e]), outc(m_g[e]), outc(m_b[e])};
  endfunction

  task automatic look(input string req, input logic [7:0] p);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    chk(req, {8'h0, pix_rgb}, {8'h0, exp_rgb(p)});
  endtask

  initial begin
    logic [7:0] d;
    n_chk = 0; n_fail = 0;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0; pix_idx = 0;
    m_idx = 0; m_ph = 0; m_sr = 0; m_sg = 0; m_mask = 8'hFF; m_mode8 = 0;
    for (int i = 0; i < 256; i++) begin m_r[i] = 0; m_g[i] = 0; m_b[i] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rgb in reset", {8'h0, pix_rgb}, 32'h0);
    rst_n = 1'b1;
    rd(2'd0, d); chk("R1 index", {24'h0, d}, 32'h00);
    rd(2'd2, d); chk("R1 mask", {24'h0, d}, 32'hFF);
    rd(2'd3, d); chk("R1 ctrl", {24'h0, d}, 32'h00);
    rd(2'd1, d); chk("R9 data read", {24'h0, d}, 32'h00);

    // R7 8-bit mode, full table load, R4 wrap
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk("R7 ctrl readback", {24'h0, d}, 32'h01);
    wr(2'd0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, 8'(i)); wr(2'd1, 8'(i) ^ 8'h5A); wr(2'd1, ~8'(i));
    end
    rd(2'd0, d); chk("R4 wrap after full load", {24'h0, d}, 32'h00);
    for (int i = 0; i < 256; i++) look("R3 R8 full sweep", 8'(i));

    // R3 partial triple not committed; R5 read clears counter
    wr(2'd0, 8'd10);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22);
    look("R3 no commit before blue", 8'd10);
    rd(2'd0, d); chk("R5 index read", {24'h0, d}, 32'd10);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC);
    look("R5 restart at red", 8'd10);
    chk("R5 value", {8'h0, pix_rgb}, 32'h00AABBCC);
    rd(2'd0, d); chk("R4 advance", {24'h0, d}, 32'd11);

    // R2 index write restarts counter
    wr(2'd0, 8'd20); wr(2'd1, 8'h01);
    wr(2'd0, 8'd21);
    wr(2'd1, 8'h31); wr(2'd1, 8'h32); wr(2'd1, 8'h33);
    look("R2 entry 20 untouched", 8'd20);
    look("R2 entry 21", 8'd21);
    chk("R2 value", {8'h0, pix_rgb}, 32'h00313233);

    // R4 wrap from 255
    wr(2'd0, 8'd255);
    wr(2'd1, 8'h77); wr(2'd1, 8'h88); wr(2'd1, 8'h99);
    rd(2'd0, d); chk("R4 wrap 255", {24'h0, d}, 32'd0);
    look("R4 entry 255", 8'd255);

    // R6 mask
    wr(2'd2, 8'h0F);
    rd(2'd2, d); chk("R6 mask readback", {24'h0, d}, 32'h0F);
    for (int i = 0; i < 256; i++) look("R6 mask 0F sweep", 8'(i));
    wr(2'd2, 8'h00);
    look("R6 mask 00", 8'hE7);
    wr(2'd2, 8'hFF);

    // R7 6-bit mode
    wr(2'd3, 8'h00);
    for (int i = 0; i < 256; i++) look("R7 narrow sweep", 8'(i));
    wr(2'd0, 8'd40);
    wr(2'd1, 8'hFF); wr(2'd1, 8'hC1); wr(2'd1, 8'h3F);
    look("R7 narrow write", 8'd40);
    chk("R7 narrow value", {8'h0, pix_rgb}, 32'h00FC04FC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule